// File: doc/BRIEF.md
# Serial Page-Bounded DMA Engine

This block moves data between a 32-bit word memory port and one serial channel. There is no length register. Each transfer is bounded by address alignment and, on the receive side, by the state of the receive queue.

A transmit command reads words starting at the command address. For each word it sends the byte in bits 15:8 to the transmitter. It stops once the next word address lands on a 4 KB page boundary.

A receive command drains the external receive queue. For each character it writes one whole memory word holding four copies of that character. It stops when the queue runs dry or when the next word address lands on a 2 KB half-page boundary. In both directions a one-cycle done pulse reports the byte count, which is four times the number of words moved. A loopback output can echo every transmitted byte back toward the receive queue.

Top module: `sdma_page_engine`

## Requirements
- R1: After reset the engine is idle. busy, done, mem_req, tx_valid, rx_pop and lb_valid are all low, and done_count is 0. While idle none of the request outputs is raised.
- R2: The engine accepts cmd_start only while idle. cmd_dir 0 selects transmit and 1 selects receive. The start address is cmd_addr with its two low bits forced to zero. busy goes high in the cycle after acceptance.
- R3: Transmit reads memory words with mem_we low at the start address, then at +4 steps. Each word's bits 15:8 are sent on tx_byte, in address order.
- R4: Transmit ends after the word whose following address (address + 4) has bits 11:2 all zero. done_count equals 4 times the number of words sent.
- R5: Receive pops one character per memory write, with mem_we high. Each write goes to the next word address, starting at the start address. The written word holds the character in all four byte lanes.
- R6: Receive ends when rx_empty is high at the point of taking a character; zero characters is allowed. It also ends after the write whose following address has bits 10:2 all zero. done_count equals 4 times the number of characters written.
- R7: While loop_en is high, every transmit handshake (tx_valid and tx_ready) also raises lb_valid in the same cycle, with lb_byte equal to tx_byte. While loop_en is low, lb_valid stays low.
- R8: Only one memory access is outstanding at a time. Once mem_req is raised, mem_addr, mem_we and mem_wdata hold steady until the cycle mem_ack is seen, and the engine advances only after that.
- R9: tx_valid and tx_byte hold steady until tx_ready is seen.
- R10: done is high for exactly one cycle at the end of a transfer, and busy is low in the next cycle. done_count keeps its value until the next accepted start. A cmd_start while busy has no effect on the transfer under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start request, taken only while idle |
| cmd_dir | input | 1 | 0 transmit, 1 receive |
| cmd_addr | input | AW | Start byte address (low two bits ignored) |
| loop_en | input | 1 | Echo transmitted bytes on the loopback port |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete (read data valid) |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_byte | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmitter takes the byte |
| rx_empty | input | 1 | Receive queue empty |
| rx_byte | input | 8 | Head of the receive queue |
| rx_pop | output | 1 | Remove the head of the receive queue |
| lb_valid | output | 1 | Loopback byte valid |
| lb_byte | output | 8 | Loopback byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| done_count | output | TX_PAGE_BITS+1 | Bytes moved by the last transfer |

## Verification
The bench aims at the last word before each boundary, because an off-by-one in the boundary test would send one word too many or stop one word short. It also starts exactly on a page, where a design testing the current address instead of the next one would stop after a single word rather than a full 1024. Receive runs cover a queue empty from the start, a queue that empties early, and a queue that outlasts the half-page; a design that ignored either stop condition would pop characters that should stay queued. Random memory acknowledge and transmitter ready delays, a misaligned start address, and a second start fired mid-transfer expose a design that advances without a handshake, honours the low address bits, or restarts while busy.

// File: rtl/sdma_pkg.sv
`timescale 1ns/1ps
package sdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX_FETCH,
        ST_TX_SEND,
        ST_RX_CHECK,
        ST_RX_WRITE,
        ST_DONE
    } sdma_state_e;

    typedef struct packed {
        logic load;     // take the command address, clear the count
        logic step;     // advance address by one word, add to count
        logic cap_mem;  // capture the character lane of the read word
        logic cap_rx;   // capture and pop the receive queue head
    } sdma_ctl_t;

    localparam int WORD_BYTES = 4;

    function automatic logic [7:0] char_lane(input logic [31:0] w);
        return w[15:8];
    endfunction

    function automatic logic [31:0] spread_char(input logic [7:0] b);
        return {WORD_BYTES{b}};
    endfunction

endpackage

// File: rtl/sdma_ctrl.sv
`timescale 1ns/1ps
module sdma_ctrl
    import sdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_start,
    input  logic        cmd_dir,
    input  logic        mem_ack,
    input  logic        tx_ready,
    input  logic        rx_empty,
    input  logic        tx_wrap,
    input  logic        rx_wrap,
    output sdma_state_e state,
    output sdma_ctl_t   ctl
);

    sdma_state_e state_nxt;

    always_comb begin
        state_nxt = state;
        ctl       = '0;
        case (state)
            ST_IDLE: begin
                if (cmd_start) begin
                    ctl.load  = 1'b1;
                    state_nxt = cmd_dir ? ST_RX_CHECK : ST_TX_FETCH;
                end
            end
            ST_TX_FETCH: begin
                if (mem_ack) begin
                    ctl.cap_mem = 1'b1;
                    state_nxt   = ST_TX_SEND;
                end
            end
            ST_TX_SEND: begin
                if (tx_ready) begin
                    ctl.step  = 1'b1;
                    state_nxt = tx_wrap ? ST_DONE : ST_TX_FETCH;
                end
            end
            ST_RX_CHECK: begin
                if (rx_empty) begin
                    state_nxt = ST_DONE;
                end else begin
                    ctl.cap_rx = 1'b1;
                    state_nxt  = ST_RX_WRITE;
                end
            end
            ST_RX_WRITE: begin
                if (mem_ack) begin
                    ctl.step  = 1'b1;
                    state_nxt = rx_wrap ? ST_DONE : ST_RX_CHECK;
                end
            end
            ST_DONE:  state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

endmodule

// File: rtl/sdma_addr_ctr.sv
`timescale 1ns/1ps
module sdma_addr_ctr #(
    parameter int AW           = 16,
    parameter int TX_PAGE_BITS = 12,
    parameter int RX_PAGE_BITS = 11,
    localparam int CW          = TX_PAGE_BITS + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] load_addr,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] count,
    output logic          tx_wrap,
    output logic          rx_wrap
);

    localparam logic [AW-1:0] WORD_MASK = ~AW'(3);

    logic [AW-1:0] addr_nxt;

    assign addr_nxt = addr + AW'(4);
    assign tx_wrap  = (addr_nxt[TX_PAGE_BITS-1:2] == '0);
    assign rx_wrap  = (addr_nxt[RX_PAGE_BITS-1:2] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr  <= '0;
            count <= '0;
        end else if (load) begin
            addr  <= load_addr & WORD_MASK;
            count <= '0;
        end else if (step) begin
            addr  <= addr_nxt;
            count <= count + CW'(4);
        end
    end

endmodule

// File: rtl/sdma_lane.sv
`timescale 1ns/1ps
module sdma_lane
    import sdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cap_mem,
    input  logic        cap_rx,
    input  logic [31:0] mem_rdata,
    input  logic [7:0]  rx_byte,
    output logic [7:0]  char_q
);

    always_ff @(posedge clk) begin
        if (rst)          char_q <= '0;
        else if (cap_mem) char_q <= char_lane(mem_rdata);
        else if (cap_rx)  char_q <= rx_byte;
    end

endmodule

// File: rtl/sdma_page_engine.sv
`timescale 1ns/1ps
module sdma_page_engine
    import sdma_pkg::*;
#(
    parameter int AW           = 16,
    parameter int TX_PAGE_BITS = 12,
    parameter int RX_PAGE_BITS = 11
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cmd_start,
    input  logic                    cmd_dir,
    input  logic [AW-1:0]           cmd_addr,
    input  logic                    loop_en,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [AW-1:0]           mem_addr,
    output logic [31:0]             mem_wdata,
    input  logic                    mem_ack,
    input  logic [31:0]             mem_rdata,
    output logic                    tx_valid,
    output logic [7:0]              tx_byte,
    input  logic                    tx_ready,
    input  logic                    rx_empty,
    input  logic [7:0]              rx_byte,
    output logic                    rx_pop,
    output logic                    lb_valid,
    output logic [7:0]              lb_byte,
    output logic                    busy,
    output logic                    done,
    output logic [TX_PAGE_BITS:0]   done_count
);

    sdma_state_e state;
    sdma_ctl_t   ctl;
    logic        tx_wrap, rx_wrap;
    logic [7:0]  char_q;

    sdma_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_start (cmd_start),
        .cmd_dir   (cmd_dir),
        .mem_ack   (mem_ack),
        .tx_ready  (tx_ready),
        .rx_empty  (rx_empty),
        .tx_wrap   (tx_wrap),
        .rx_wrap   (rx_wrap),
        .state     (state),
        .ctl       (ctl)
    );

    sdma_addr_ctr #(
        .AW           (AW),
        .TX_PAGE_BITS (TX_PAGE_BITS),
        .RX_PAGE_BITS (RX_PAGE_BITS)
    ) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (ctl.load),
        .step      (ctl.step),
        .load_addr (cmd_addr),
        .addr      (mem_addr),
        .count     (done_count),
        .tx_wrap   (tx_wrap),
        .rx_wrap   (rx_wrap)
    );

    sdma_lane u_lane (
        .clk       (clk),
        .rst       (rst),
        .cap_mem   (ctl.cap_mem),
        .cap_rx    (ctl.cap_rx),
        .mem_rdata (mem_rdata),
        .rx_byte   (rx_byte),
        .char_q    (char_q)
    );

    assign mem_req   = (state == ST_TX_FETCH) || (state == ST_RX_WRITE);
    assign mem_we    = (state == ST_RX_WRITE);
    assign mem_wdata = spread_char(char_q);
    assign tx_valid  = (state == ST_TX_SEND);
    assign tx_byte   = char_q;
    assign rx_pop    = ctl.cap_rx;
    assign lb_valid  = tx_valid && tx_ready && loop_en;
    assign lb_byte   = char_q;
    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_DONE);

endmodule

// File: rtl/sdma_checker.sv
`timescale 1ns/1ps
module sdma_checker #(
    parameter int AW           = 16,
    parameter int TX_PAGE_BITS = 12
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  mem_req,
    input logic                  mem_we,
    input logic [AW-1:0]         mem_addr,
    input logic [31:0]           mem_wdata,
    input logic                  mem_ack,
    input logic                  tx_valid,
    input logic [7:0]            tx_byte,
    input logic                  tx_ready,
    input logic                  rx_pop,
    input logic                  rx_empty,
    input logic                  busy,
    input logic                  done,
    input logic [TX_PAGE_BITS:0] done_count
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !tx_valid && !rx_pop && !done));

    p_word_align_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    p_spread_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_wdata[7:0] == mem_wdata[15:8] &&
                                 mem_wdata[15:8] == mem_wdata[23:16] &&
                                 mem_wdata[23:16] == mem_wdata[31:24]));

    p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> (!rx_empty && busy));

    p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    p_tx_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy && $stable(done_count)));

    p_count_words_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (done_count[1:0] == 2'b00));

endmodule

bind sdma_page_engine sdma_checker #(
    .AW           (AW),
    .TX_PAGE_BITS (TX_PAGE_BITS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .tx_valid   (tx_valid),
    .tx_byte    (tx_byte),
    .tx_ready   (tx_ready),
    .rx_pop     (rx_pop),
    .rx_empty   (rx_empty),
    .busy       (busy),
    .done       (done),
    .done_count (done_count)
);

// File: tb/tb_sdma_page_engine.sv
`timescale 1ns/1ps
module tb_sdma_page_engine;

    localparam int AW = 16;
    localparam int CW = 13;

    logic          clk = 1'b0;
    logic          rst;
    logic          cmd_start, cmd_dir, loop_en;
    logic [AW-1:0] cmd_addr;
    logic          mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata;
    logic          tx_valid, tx_ready;
    logic [7:0]    tx_byte;
    logic          rx_empty, rx_pop;
    logic [7:0]    rx_byte;
    logic          lb_valid;
    logic [7:0]    lb_byte;
    logic          busy, done;
    logic [CW-1:0] done_count;

    always #2.5 clk = ~clk;

    sdma_page_engine dut (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_dir(cmd_dir),
        .cmd_addr(cmd_addr), .loop_en(loop_en), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .tx_ready(tx_ready), .rx_empty(rx_empty),
        .rx_byte(rx_byte), .rx_pop(rx_pop), .lb_valid(lb_valid),
        .lb_byte(lb_byte), .busy(busy), .done(done), .done_count(done_count)
    );

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0]    tx_log [0:1023];
    logic [7:0]    lb_log [0:1023];
    logic [AW-1:0] rd_log [0:1023];
    logic [AW-1:0] wa_log [0:1023];
    logic [31:0]   wd_log [0:1023];
    int tx_n, lb_n, rd_n, wr_n, done_n;
    logic [7:0]    rxq [0:63];
    int rxq_head, rxq_len;

    function automatic logic [31:0] memf(input logic [AW-1:0] a);
        logic [7:0] c;
        c = a[9:2] * 8'd5 + 8'd1;
        return {a[15:8], a[7:0], c, ~a[7:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Environment: memory, transmitter, receive queue, all driven at negedge
    initial begin
        mem_ack = 1'b0; mem_rdata = '0; tx_ready = 1'b0;
        rx_empty = 1'b1; rx_byte = '0;
        forever begin
            @(negedge clk);
            mem_ack   = mem_req && ($urandom_range(0, 2) != 0);
            mem_rdata = memf(mem_addr);
            tx_ready  = ($urandom_range(0, 3) != 0);
            rx_empty  = (rxq_head >= rxq_len);
            rx_byte   = rx_empty ? 8'h00 : rxq[rxq_head];
            #1;
            if (done) done_n++;
            if (mem_req && mem_ack) begin
                if (mem_we) begin
                    if (wr_n < 1024) begin wa_log[wr_n] = mem_addr; wd_log[wr_n] = mem_wdata; end
                    wr_n++;
                end else begin
                    if (rd_n < 1024) rd_log[rd_n] = mem_addr;
                    rd_n++;
                end
            end
            if (tx_valid && tx_ready) begin
                if (tx_n < 1024) tx_log[tx_n] = tx_byte;
                tx_n++;
            end
            if (lb_valid) begin
                if (lb_n < 1024) lb_log[lb_n] = lb_byte;
                lb_n++;
            end
            if (rx_pop) rxq_head++;
        end
    end

    task automatic clear_logs();
        tx_n = 0; lb_n = 0; rd_n = 0; wr_n = 0; done_n = 0;
    endtask

    task automatic launch(input bit dir, input logic [AW-1:0] a, input bit poke);
        @(negedge clk);
        cmd_start = 1'b1; cmd_dir = dir; cmd_addr = a;
        @(negedge clk);
        cmd_start = 1'b0;
        #2;
        chk(busy === 1'b1, "R2", "busy after start", int'(busy), 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            cmd_start = 1'b1; cmd_dir = ~dir; cmd_addr = 16'h0004;
            @(negedge clk);
            cmd_start = 1'b0;
        end
    endtask

    task automatic wait_done();
        int t = 0;
        while (done_n == 0 && t < 20000) begin
            @(negedge clk); #2; t++;
        end
        chk(done_n != 0, "R10", "transfer finished", t, 0);
        repeat (3) @(negedge clk);
        #2;
        chk(done_n == 1 && busy == 1'b0, "R10", "single done pulse then idle", done_n, 1);
    endtask

    task automatic run_tx(input logic [AW-1:0] a, input bit lb, input bit poke);
        logic [AW-1:0] aa;
        int nw, bad_b, bad_a, bad_l;
        aa = a & ~AW'(3);
        nw = 1024 - int'(aa[11:2]);
        clear_logs();
        rxq_head = 0; rxq_len = 0;
        @(negedge clk); loop_en = lb;
        launch(1'b0, a, poke);
        wait_done();
        chk(tx_n == nw, "R4", "words sent", tx_n, nw);
        chk(rd_n == nw && wr_n == 0, "R3", "memory reads only", rd_n, nw);
        bad_b = 0; bad_a = 0;
        for (int i = 0; i < nw && i < tx_n && i < rd_n; i++) begin
            if (tx_log[i] !== memf(aa + AW'(4*i))[15:8]) bad_b++;
            if (rd_log[i] !== aa + AW'(4*i)) bad_a++;
        end
        chk(bad_b == 0, "R3", "lane-1 bytes sent", bad_b, 0);
        chk(bad_a == 0, "R2", "read addresses from aligned start", bad_a, 0);
        chk(int'(done_count) == 4*nw, "R4", "done_count", int'(done_count), 4*nw);
        chk(lb_n == (lb ? nw : 0), "R7", "loopback bytes", lb_n, lb ? nw : 0);
        bad_l = 0;
        for (int i = 0; i < lb_n && i < tx_n; i++)
            if (lb_log[i] !== tx_log[i]) bad_l++;
        chk(bad_l == 0, "R7", "loopback matches transmit", bad_l, 0);
    endtask

    task automatic run_rx(input logic [AW-1:0] a, input int nch, input bit poke);
        logic [AW-1:0] aa;
        int nmax, ne, bad;
        aa = a & ~AW'(3);
        nmax = 512 - int'(aa[10:2]);
        ne = (nch < nmax) ? nch : nmax;
        clear_logs();
        @(negedge clk);
        loop_en = 1'b0;
        for (int i = 0; i < nch; i++) rxq[i] = 8'($urandom_range(0, 255));
        rxq_head = 0; rxq_len = nch;
        launch(1'b1, a, poke);
        wait_done();
        chk(wr_n == ne && rd_n == 0 && tx_n == 0, "R5", "writes only", wr_n, ne);
        chk(rxq_head == ne, "R6", "characters popped", rxq_head, ne);
        bad = 0;
        for (int i = 0; i < ne && i < wr_n; i++) begin
            if (wa_log[i] !== aa + AW'(4*i)) bad++;
            if (wd_log[i] !== {4{rxq[i]}}) bad++;
        end
        chk(bad == 0, "R5", "write address and replicated data", bad, 0);
        chk(int'(done_count) == 4*ne, "R6", "done_count", int'(done_count), 4*ne);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [AW-1:0] a;
        process::self().srandom(32'd1357);
        rxq_head = 0; rxq_len = 0; clear_logs();
        rst = 1'b1; cmd_start = 1'b0; cmd_dir = 1'b0; cmd_addr = '0; loop_en = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #2;
        chk(!busy && !done && !mem_req && !tx_valid && !rx_pop && !lb_valid,
            "R1", "outputs idle after reset", int'(busy), 0);
        chk(done_count == '0, "R1", "count after reset", int'(done_count), 0);

        run_tx(16'h0FF4, 1'b0, 1'b0);   // last three words of a page
        run_tx(16'h2FF7, 1'b1, 1'b0);   // misaligned start, loopback on
        run_tx(16'h3000, 1'b0, 1'b0);   // full page from a boundary
        run_tx(16'h4FE0, 1'b1, 1'b1);   // start while busy (R10)
        run_rx(16'h07F8, 5, 1'b0);      // half-page stop, chars left over
        run_rx(16'h0100, 0, 1'b0);      // empty queue from the outset
        run_rx(16'h0200, 6, 1'b1);      // queue empties, start while busy
        run_rx(16'h0A02, 3, 1'b0);      // misaligned receive start
        run_rx(16'h1000, 4, 1'b0);      // from a half-page boundary

        for (int k = 0; k < 12; k++) begin
            if ($urandom_range(0, 1) == 0) begin
                a = {4'($urandom_range(0, 15)), 12'h000} - AW'(4*$urandom_range(1, 12));
                run_tx(a | AW'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'b0);
            end else begin
                a = {5'($urandom_range(0, 31)), 11'h000} - AW'(4*$urandom_range(1, 12));
                run_rx(a, $urandom_range(0, 15), 1'b0);
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule